// File: doc/BRIEF.md
# Write-Data Request Scheduler

This block sits on the physical-layer side of a DRAM memory controller and turns each accepted write CAS into a timed request for write data. One system clock spans four DRAM command slots, and a CAS may occupy only slot 0 or slot 2. For every write CAS, the block works out the system cycle on which data and mask must be presented. That cycle follows from the sub-cycle slot of the CAS plus the programmed write latency, which is CWL plus AL counted in DRAM clocks. The block raises a one-cycle data-request strobe on the system cycle before that one.

With each request the block returns the buffer tag and the rank captured with the CAS. It also returns the DRAM-clock offset inside the data cycle, which tells the serializer where the burst starts. No data is held here: data is pulled just in time. Two CAS commands on consecutive cycles can therefore give requests that are not on consecutive cycles, because the slot moves the target.

The block checks every CAS as it arrives. It drops a CAS that comes before calibration completes, one with an illegal or inconsistent slot code, one with a latency setting outside the supported range, and one whose request would land on a cycle that is already taken. Each of these raises a one-cycle error pulse.

Top module: `wr_data_req_sched`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wd_req`, all four error outputs and all request fields read zero. A reset also discards every pending request.
- R2: A write CAS is accepted in cycle N when `wr_cas` and `cal_done` are high, `cas_slot` is 0 or 2, `cas_slot_hi` equals bit 1 of `cas_slot`, and `wr_lat` lies in 8..MAX_LAT. For an accepted CAS, `wd_req` is high for exactly one cycle, in cycle N + floor((cas_slot + wr_lat)/4) - 1.
- R3: While `wd_req` is high, `wd_req_tag` and `wd_req_rank` carry the `cas_tag` and `cas_rank` sampled with that CAS. `wd_req_phase` carries (cas_slot + wr_lat) mod 4. While `wd_req` is low, all three read zero.
- R4: A CAS while `cal_done` is low is dropped and produces no request. `err_early` pulses high in cycle N+1.
- R5: A CAS with `cal_done` high and an odd `cas_slot`, or with `cas_slot_hi` different from bit 1 of `cas_slot`, is dropped. `err_slot` pulses in cycle N+1.
- R6: A CAS with a legal slot whose `wr_lat` is below 8 or above MAX_LAT is dropped. `err_lat` pulses in cycle N+1.
- R7: One CAS per cycle is sustained. Every accepted CAS yields its own request, even where requests from back-to-back CAS commands are not adjacent.
- R8: If an accepted CAS targets a request cycle that an earlier CAS already holds, the earlier request is kept and the new one is dropped. `err_overlap` pulses in cycle N+1.
- R9: A single CAS raises at most one of `err_early`, `err_slot` and `err_lat`. The order of precedence is early, then slot, then latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_done | input | 1 | Calibration complete; gates CAS acceptance |
| wr_cas | input | 1 | Write CAS issued this cycle |
| cas_slot | input | 2 | Command slot of the CAS (0 or 2) |
| cas_slot_hi | input | 1 | Duplicate of bit 1 of the slot select |
| cas_rank | input | RANK_W | Target rank of the CAS |
| cas_tag | input | TAG_W | Write buffer tag of the CAS |
| wr_lat | input | LAT_W | CWL plus AL in DRAM clocks |
| wd_req | output | 1 | Write data needed on the next cycle |
| wd_req_tag | output | TAG_W | Buffer tag for the requested data |
| wd_req_rank | output | RANK_W | Rank for the requested data |
| wd_req_phase | output | 2 | DRAM-clock offset of the burst in the data cycle |
| err_early | output | 1 | CAS arrived before calibration |
| err_slot | output | 1 | Illegal or inconsistent slot code |
| err_lat | output | 1 | Latency setting out of range |
| err_overlap | output | 1 | Request cycle already taken |

## Verification
The bench builds the block with MAX_LAT = 20, a 4-bit tag, a 2-bit rank and a 5-bit latency input. The pending-request line is then only seven stages deep, so its deepest insertion point is exercised with latency 20 from slot 2. A latency of 21 fits on the port, so the upper range error can be driven as well. The lower limit of 8 and a slot-0/slot-2 pair placed so that its requests collide are also within reach, together with a reset that arrives while a request is still pending.

// File: rtl/wdreq_pkg.sv
package wdreq_pkg;

   localparam int SLOTS_PER_CLK = 4;
   localparam int SLOT_W        = 2;
   // Smallest latency whose request still lands at least one cycle after the CAS
   localparam int MIN_LAT       = 2 * SLOTS_PER_CLK;

   typedef struct packed {
      logic early;
      logic slot;
      logic lat;
      logic overlap;
   } wdreq_err_t;

   // Even slot and duplicate bit consistent with the slot select
   function automatic logic slot_legal(input logic [SLOT_W-1:0] s, input logic hi);
      return (s[0] == 1'b0) && (hi == s[1]);
   endfunction

endpackage

// File: rtl/wdreq_cas_check.sv
module wdreq_cas_check
   import wdreq_pkg::*;
#(
   parameter int MAX_LAT = 48,
   parameter int LAT_W   = 6,
   parameter int IDX_W   = 4
) (
   input  logic              cal_done,
   input  logic              wr_cas,
   input  logic [SLOT_W-1:0] cas_slot,
   input  logic              cas_slot_hi,
   input  logic [LAT_W-1:0]  wr_lat,
   output logic              accept,
   output logic              bad_early,
   output logic              bad_slot,
   output logic              bad_lat,
   output logic [IDX_W-1:0]  ins_idx,
   output logic [SLOT_W-1:0] ins_phase
);

   localparam int SUM_W = LAT_W + 1;

   logic [SUM_W-1:0] total;
   logic             sok;
   logic             lok;

   always_comb begin
      total = SUM_W'(cas_slot) + SUM_W'(wr_lat);
      sok   = slot_legal(cas_slot, cas_slot_hi);
      lok   = (int'(wr_lat) >= MIN_LAT) && (int'(wr_lat) <= MAX_LAT);
   end

   // Precedence: calibration, then slot code, then latency
   always_comb begin
      bad_early = wr_cas && !cal_done;
      bad_slot  = wr_cas && cal_done && !sok;
      bad_lat   = wr_cas && cal_done && sok && !lok;
      accept    = wr_cas && cal_done && sok && lok;
   end

   // Request goes out one system cycle before the data cycle; the stage
   // index counts the cycles after the one that follows the CAS.
   always_comb begin
      int d;
      d = int'(total) / SLOTS_PER_CLK - 2;
      ins_idx   = accept ? IDX_W'(d) : '0;
      ins_phase = total[SLOT_W-1:0];
   end

endmodule

// File: rtl/wdreq_delay_line.sv
module wdreq_delay_line #(
   parameter int DEPTH  = 14,
   parameter int TAG_W  = 5,
   parameter int RANK_W = 2,
   parameter int PH_W   = 2,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins,
   input  logic [IDX_W-1:0]  ins_idx,
   input  logic [TAG_W-1:0]  ins_tag,
   input  logic [RANK_W-1:0] ins_rank,
   input  logic [PH_W-1:0]   ins_phase,
   output logic              head_v,
   output logic [TAG_W-1:0]  head_tag,
   output logic [RANK_W-1:0] head_rank,
   output logic [PH_W-1:0]   head_phase,
   output logic              collide
);

   logic [DEPTH-1:0]             v;
   logic [DEPTH-1:0]             v_up;
   logic [DEPTH-1:0][TAG_W-1:0]  tg;
   logic [DEPTH-1:0][TAG_W-1:0]  tg_up;
   logic [DEPTH-1:0][RANK_W-1:0] rk;
   logic [DEPTH-1:0][RANK_W-1:0] rk_up;
   logic [DEPTH-1:0][PH_W-1:0]   ph;
   logic [DEPTH-1:0][PH_W-1:0]   ph_up;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      // What this stage takes when nothing is inserted: the stage above it
      if (i == DEPTH - 1) begin : g_last
         assign v_up[i]  = 1'b0;
         assign tg_up[i] = '0;
         assign rk_up[i] = '0;
         assign ph_up[i] = '0;
      end else begin : g_mid
         assign v_up[i]  = v[i+1];
         assign tg_up[i] = tg[i+1];
         assign rk_up[i] = rk[i+1];
         assign ph_up[i] = ph[i+1];
      end

      logic              s_v;
      logic [TAG_W-1:0]  s_tg;
      logic [RANK_W-1:0] s_rk;
      logic [PH_W-1:0]   s_ph;
      logic              load;

      // An occupied target keeps the older request
      assign load = ins && (ins_idx == IDX_W'(i)) && !v_up[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_v  <= 1'b0;
            s_tg <= '0;
            s_rk <= '0;
            s_ph <= '0;
         end else if (load) begin
            s_v  <= 1'b1;
            s_tg <= ins_tag;
            s_rk <= ins_rank;
            s_ph <= ins_phase;
         end else begin
            s_v  <= v_up[i];
            s_tg <= tg_up[i];
            s_rk <= rk_up[i];
            s_ph <= ph_up[i];
         end
      end

      assign v[i]  = s_v;
      assign tg[i] = s_tg;
      assign rk[i] = s_rk;
      assign ph[i] = s_ph;
   end

   assign collide    = ins && v_up[ins_idx];
   assign head_v     = v[0];
   assign head_tag   = tg[0];
   assign head_rank  = rk[0];
   assign head_phase = ph[0];

endmodule

// File: rtl/wr_data_req_sched.sv
module wr_data_req_sched
   import wdreq_pkg::*;
#(
   parameter int MAX_LAT = 48,
   parameter int TAG_W   = 5,
   parameter int RANK_W  = 2,
   parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_done,
   input  logic              wr_cas,
   input  logic [1:0]        cas_slot,
   input  logic              cas_slot_hi,
   input  logic [RANK_W-1:0] cas_rank,
   input  logic [TAG_W-1:0]  cas_tag,
   input  logic [LAT_W-1:0]  wr_lat,
   output logic              wd_req,
   output logic [TAG_W-1:0]  wd_req_tag,
   output logic [RANK_W-1:0] wd_req_rank,
   output logic [1:0]        wd_req_phase,
   output logic              err_early,
   output logic              err_slot,
   output logic              err_lat,
   output logic              err_overlap
);

   localparam int DEPTH = MAX_LAT / SLOTS_PER_CLK + 2;
   localparam int IDX_W = $clog2(DEPTH);

   if (MAX_LAT < MIN_LAT) begin : g_chk_lat
      $error("MAX_LAT must be at least %0d", MIN_LAT);
   end
   if (LAT_W < $clog2(MAX_LAT + 1)) begin : g_chk_latw
      $error("LAT_W too narrow for MAX_LAT");
   end
   if (TAG_W < 1 || RANK_W < 1) begin : g_chk_fields
      $error("TAG_W and RANK_W must be positive");
   end

   logic              accept;
   logic              bad_early;
   logic              bad_slot;
   logic              bad_lat;
   logic [IDX_W-1:0]  ins_idx;
   logic [SLOT_W-1:0] ins_phase;
   logic              collide;
   wdreq_err_t        err_q;

   wdreq_cas_check #(
      .MAX_LAT (MAX_LAT),
      .LAT_W   (LAT_W),
      .IDX_W   (IDX_W)
   ) cas_check_i (
      .cal_done    (cal_done),
      .wr_cas      (wr_cas),
      .cas_slot    (cas_slot),
      .cas_slot_hi (cas_slot_hi),
      .wr_lat      (wr_lat),
      .accept      (accept),
      .bad_early   (bad_early),
      .bad_slot    (bad_slot),
      .bad_lat     (bad_lat),
      .ins_idx     (ins_idx),
      .ins_phase   (ins_phase)
   );

   wdreq_delay_line #(
      .DEPTH  (DEPTH),
      .TAG_W  (TAG_W),
      .RANK_W (RANK_W),
      .PH_W   (SLOT_W),
      .IDX_W  (IDX_W)
   ) line_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins        (accept),
      .ins_idx    (ins_idx),
      .ins_tag    (cas_tag),
      .ins_rank   (cas_rank),
      .ins_phase  (ins_phase),
      .head_v     (wd_req),
      .head_tag   (wd_req_tag),
      .head_rank  (wd_req_rank),
      .head_phase (wd_req_phase),
      .collide    (collide)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= '0;
      end else begin
         err_q.early   <= bad_early;
         err_q.slot    <= bad_slot;
         err_q.lat     <= bad_lat;
         err_q.overlap <= collide;
      end
   end

   assign err_early   = err_q.early;
   assign err_slot    = err_q.slot;
   assign err_lat     = err_q.lat;
   assign err_overlap = err_q.overlap;

endmodule

// File: rtl/wdreq_checker.sv
module wdreq_checker #(
   parameter int MAX_LAT = 48,
   parameter int TAG_W   = 5,
   parameter int RANK_W  = 2,
   parameter int LAT_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cal_done,
   input logic              wr_cas,
   input logic [1:0]        cas_slot,
   input logic              cas_slot_hi,
   input logic [TAG_W-1:0]  cas_tag,
   input logic [LAT_W-1:0]  wr_lat,
   input logic              wd_req,
   input logic [TAG_W-1:0]  wd_req_tag,
   input logic [RANK_W-1:0] wd_req_rank,
   input logic [1:0]        wd_req_phase,
   input logic              err_early,
   input logic              err_slot,
   input logic              err_lat,
   input logic              err_overlap
);

   logic slot_good;
   assign slot_good = !cas_slot[0] && (cas_slot_hi == cas_slot[1]);

   AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_req |-> (wd_req_tag == '0 && wd_req_rank == '0 && wd_req_phase == '0)); // R3

   AST_EARLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cas && !cal_done) |=> err_early); // R4

   AST_SLOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cas && cal_done && !slot_good) |=> err_slot); // R5

   AST_LAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cas && cal_done && slot_good && (int'(wr_lat) < 8 || int'(wr_lat) > MAX_LAT))
      |=> err_lat); // R6

   AST_MIN_DELAY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cas && cal_done && slot_good && int'(wr_lat) >= 8
       && (int'(cas_slot) + int'(wr_lat)) < 12)
      |=> (wd_req && (err_overlap || wd_req_tag == $past(cas_tag)))); // R2

   AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_early, err_slot, err_lat})); // R9

endmodule

bind wr_data_req_sched wdreq_checker #(
   .MAX_LAT (MAX_LAT),
   .TAG_W   (TAG_W),
   .RANK_W  (RANK_W),
   .LAT_W   (LAT_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cal_done     (cal_done),
   .wr_cas       (wr_cas),
   .cas_slot     (cas_slot),
   .cas_slot_hi  (cas_slot_hi),
   .cas_tag      (cas_tag),
   .wr_lat       (wr_lat),
   .wd_req       (wd_req),
   .wd_req_tag   (wd_req_tag),
   .wd_req_rank  (wd_req_rank),
   .wd_req_phase (wd_req_phase),
   .err_early    (err_early),
   .err_slot     (err_slot),
   .err_lat      (err_lat),
   .err_overlap  (err_overlap)
);

// File: tb/wr_data_req_sched_tb_top.sv
module wr_data_req_sched_tb_top;

   localparam int MAX_LAT = 20;
   localparam int TAG_W   = 4;
   localparam int RANK_W  = 2;
   localparam int LAT_W   = 5;
   localparam int NV      = 18;
   localparam int NE      = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cal_done = 1'b0;
   logic              wr_cas = 1'b0;
   logic [1:0]        cas_slot = '0;
   logic              cas_slot_hi = 1'b0;
   logic [RANK_W-1:0] cas_rank = '0;
   logic [TAG_W-1:0]  cas_tag = '0;
   logic [LAT_W-1:0]  wr_lat = LAT_W'(10);
   logic              wd_req;
   logic [TAG_W-1:0]  wd_req_tag;
   logic [RANK_W-1:0] wd_req_rank;
   logic [1:0]        wd_req_phase;
   logic              err_early;
   logic              err_slot;
   logic              err_lat;
   logic              err_overlap;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   wr_data_req_sched #(
      .MAX_LAT (MAX_LAT),
      .TAG_W   (TAG_W),
      .RANK_W  (RANK_W),
      .LAT_W   (LAT_W)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cal_done     (cal_done),
      .wr_cas       (wr_cas),
      .cas_slot     (cas_slot),
      .cas_slot_hi  (cas_slot_hi),
      .cas_rank     (cas_rank),
      .cas_tag      (cas_tag),
      .wr_lat       (wr_lat),
      .wd_req       (wd_req),
      .wd_req_tag   (wd_req_tag),
      .wd_req_rank  (wd_req_rank),
      .wd_req_phase (wd_req_phase),
      .err_early    (err_early),
      .err_slot     (err_slot),
      .err_lat      (err_lat),
      .err_overlap  (err_overlap)
   );

   // {cal, cas, slot[1:0], slot_hi, rank[1:0], tag[3:0], lat[4:0]}
   function automatic logic [15:0] mkv(int cal, int cas, int slot, int hi,
                                       int rank, int tag, int lat);
      return {1'(cal), 1'(cas), 2'(slot), 1'(hi), 2'(rank), 4'(tag), 5'(lat)};
   endfunction

   localparam logic [15:0] VEC [NV] = '{
      mkv(0, 1, 0, 0, 0,  0, 10),   // before calibration: R4
      mkv(1, 0, 1, 0, 0,  0,  3),   // idle with junk fields
      mkv(1, 1, 0, 0, 1,  1, 10),   // slot 0, lat 10 -> next cycle
      mkv(1, 1, 2, 1, 2,  2, 10),   // slot 2, lat 10
      mkv(1, 1, 0, 0, 0,  3, 13),
      mkv(1, 1, 2, 1, 3,  4, 13),   // back-to-back, gaps in requests: R7
      mkv(1, 1, 1, 0, 0,  0, 10),   // odd slot: R5
      mkv(1, 1, 2, 0, 0,  0, 10),   // duplicate bit mismatch: R5
      mkv(1, 1, 0, 0, 0,  0,  7),   // below min latency: R6
      mkv(1, 1, 0, 0, 0,  0, 21),   // above max latency: R6
      mkv(1, 1, 2, 1, 3,  5, 20),   // deepest insertion
      mkv(1, 1, 0, 0, 1,  6, 20),
      mkv(1, 1, 2, 1, 2,  7, 10),   // collides with tag 5: R8
      mkv(1, 0, 0, 0, 0,  0, 10),
      mkv(0, 1, 1, 0, 0,  0,  7),   // all faults, early wins: R9
      mkv(1, 1, 1, 1, 0,  0,  7),   // slot beats latency: R9
      mkv(1, 1, 0, 0, 2,  9,  8),   // min latency
      mkv(1, 1, 2, 1, 1, 10, 20)
   };

   logic              e_v     [NE];
   logic [TAG_W-1:0]  e_tag   [NE];
   logic [RANK_W-1:0] e_rank  [NE];
   logic [1:0]        e_ph    [NE];
   logic [3:0]        e_err   [NE];   // {early, slot, lat, overlap}

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected behaviour from the requirements for one driven cycle
   task automatic model(int c, logic [15:0] vv);
      int cal, cas, slot, hi, lat, d, t;
      cal  = int'(vv[15]);
      cas  = int'(vv[14]);
      slot = int'(vv[13:12]);
      hi   = int'(vv[11]);
      lat  = int'(vv[4:0]);
      if (cas == 0) return;
      if (cal == 0) e_err[c+1] = 4'b1000;
      else if ((slot % 2) != 0 || hi != slot / 2) e_err[c+1] = 4'b0100;
      else if (lat < 8 || lat > MAX_LAT) e_err[c+1] = 4'b0010;
      else begin
         d = (slot + lat) / 4 - 1;
         t = c + d;
         if (e_v[t]) e_err[c+1] = 4'b0001;
         else begin
            e_v[t]    = 1'b1;
            e_tag[t]  = vv[8:5];
            e_rank[t] = vv[10:9];
            e_ph[t]   = 2'((slot + lat) % 4);
         end
      end
   endtask

   task automatic drive(logic [15:0] vv);
      cal_done    = vv[15];
      wr_cas      = vv[14];
      cas_slot    = vv[13:12];
      cas_slot_hi = vv[11];
      cas_rank    = vv[10:9];
      cas_tag     = vv[8:5];
      wr_lat      = vv[4:0];
   endtask

   task automatic check_all_zero(string req);
      check(req, 32'({wd_req, wd_req_tag, wd_req_rank, wd_req_phase}), 32'd0);
      check(req, 32'({err_early, err_slot, err_lat, err_overlap}), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NE; i++) begin
         e_v[i] = 1'b0; e_tag[i] = '0; e_rank[i] = '0; e_ph[i] = '0; e_err[i] = '0;
      end

      // R1: reset state
      repeat (3) @(negedge clk);
      check_all_zero("R1");
      rst_n = 1'b1;

      // Table walk; cycle c is sampled at its negedge, then its inputs are driven
      for (int c = 0; c < NV + 8; c++) begin
         @(negedge clk);
         check("R2,R3,R7", 32'({wd_req, wd_req_tag, wd_req_rank, wd_req_phase}),
               32'({e_v[c], e_tag[c], e_rank[c], e_ph[c]}));
         check("R4,R5,R6,R8,R9", 32'({err_early, err_slot, err_lat, err_overlap}),
               32'(e_err[c]));
         if (c < NV) begin
            model(c, VEC[c]);
            drive(VEC[c]);
         end else begin
            drive(mkv(1, 0, 0, 0, 0, 0, 10));
         end
      end

      // R1: reset discards a pending request (would fire 4 cycles later)
      @(negedge clk);
      drive(mkv(1, 1, 2, 1, 3, 11, 20));
      @(negedge clk);
      drive(mkv(1, 0, 0, 0, 0, 0, 10));
      rst_n = 1'b0;
      @(negedge clk);
      check_all_zero("R1");
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R1", 32'({wd_req, wd_req_tag, wd_req_rank, wd_req_phase}), 32'd0);
      end

      // R2: min latency from slot 2 (total 10) right after reset
      drive(mkv(1, 1, 2, 1, 2, 13, 8));
      @(negedge clk);
      drive(mkv(1, 0, 0, 0, 0, 0, 10));
      check("R2,R3", 32'({wd_req, wd_req_tag, wd_req_rank, wd_req_phase}),
            32'({1'b1, 4'd13, 2'd2, 2'd2}));
      @(negedge clk);
      check("R2", 32'(wd_req), 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule